// File: doc/BRIEF.md
# Byte-Weighted Four-Queue Transmit Scheduler

This block decides which of four transmit descriptor queues may move its next packet from host memory into the transmit FIFO. It runs a deficit round-robin: each queue holds a programmable byte quantum (its weight), and a per-queue byte deficit counts how much of that quantum is still unspent. Whole packets are granted one at a time. The grant stays up until the DMA engine signals that the transfer has finished, and only then is the packet length charged against the deficit.

Software can rewrite the weights at any time. A written value is kept in a shadow copy and becomes active only when no packet is in flight. Every weight write, including a write of the value already held, also causes a preemption. Once the current packet completes, all deficits are cleared and service restarts at queue 0. A queue with weight zero earns no credit and is served only when it is the sole queue with a packet waiting.

Top module: `txq_dwrr_sched`

## Requirements
- R1: After reset no grant is asserted and `grant_idx` is 0. Every weight holds 512 bytes. All deficits are zero, and the first queue visited is queue 0.
- R2: `grant` is one-hot or zero. Bit i of `grant` means queue i is granted, and when `grant` is non-zero `grant_idx` equals i. A grant is only issued to a queue whose `q_valid` bit was set when the choice was made.
- R3: A grant stays unchanged from the cycle it appears until `xfer_done` is sampled high. It is removed on the edge that samples `xfer_done`. The granted head length is charged against that queue's deficit at that point.
- R4: Queues are visited in ascending order, 0 to 3, wrapping around. On its turn a queue with a packet pending gains its weight in credit. It then keeps receiving grants while its deficit is at least its head length. With equal lengths that divide the weights, each turn yields exactly weight/length packets.
- R5: Over a long run with every queue backlogged, the bytes each queue moves track the ratio of the weights. The error stays within two rounds' worth of bytes.
- R6: A queue that has no packet pending when visited has its deficit cleared. Leftover credit is not carried into a later turn.
- R7: A zero-weight queue is granted only while it is the sole valid queue. Such a grant does not change its deficit.
- R8: A weight write is latched into a shadow copy. The copy reaches the active weight only while no packet is in flight. A write during a transfer leaves the current grant untouched.
- R9: Any weight write, even of an unchanged value, takes effect as follows once no packet is in flight: every deficit is cleared and queue 0 is served next.
- R10: `xfer_done` while no grant is asserted has no effect.
- R11: No deficit overflows its 17-bit width or goes below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_valid | input | 4 | Per-queue flag: a head-of-line packet is pending |
| q_len | input | 64 | Head packet length in bytes; queue i in bits [16i+15:16i] |
| xfer_done | input | 1 | Strobe: the granted packet has been moved |
| wgt_wr_en | input | 1 | Weight register write enable |
| wgt_wr_sel | input | 2 | Index of the weight register written |
| wgt_wr_data | input | 16 | New weight in bytes |
| grant | output | 4 | One-hot grant to the chosen queue |
| grant_idx | output | 2 | Index of the granted queue |

## Verification
Two events can meet in one cycle: a weight write and the completion strobe. A weight write demands a preemption, and the completion strobe charges the deficit and ends the grant. The bench drives the write on exactly the same clock as `xfer_done`, in the middle of a queue's turn. It then requires the next grant to go to queue 0 and the next ten grants to follow the weight pattern from a clean start. If the charge were lost, or the preemption were lost or applied twice, the order would differ. A second case writes a new weight while a grant is held for several cycles. The bench checks that the grant does not move and that the restarted schedule already uses the new quantum.

// File: rtl/txq_sched_pkg.sv
package txq_sched_pkg;

    // Scheduler phase: give credit to the pointed queue, try to pick a
    // packet from it, or wait for the granted packet to finish.
    typedef enum logic [1:0] {
        PH_CREDIT = 2'd0,
        PH_PICK   = 2'd1,
        PH_XFER   = 2'd2
    } sched_phase_e;

endpackage

// File: rtl/txq_weight_bank.sv
module txq_weight_bank #(
    parameter int NQ         = 4,
    parameter int W_W        = 16,
    parameter int RST_WEIGHT = 512,
    localparam int IDX_W     = $clog2(NQ)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [IDX_W-1:0]        wr_sel,
    input  logic [W_W-1:0]          wr_data,
    input  logic                    commit,
    input  logic                    preempt_ack,
    output logic [NQ-1:0][W_W-1:0]  active_w,
    output logic                    preempt_req
);

    typedef struct packed {
        logic [NQ-1:0][W_W-1:0] shadow;
        logic [NQ-1:0][W_W-1:0] active;
        logic                   pend;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.shadow[wr_sel] = wr_data;
        end
        // Packet boundary: the freshest shadow values become active.
        if (commit) begin
            st_d.active = st_d.shadow;
        end
        if (preempt_ack) begin
            st_d.pend = 1'b0;
        end
        if (wr_en) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shadow <= {NQ{W_W'(RST_WEIGHT)}};
            st_q.active <= {NQ{W_W'(RST_WEIGHT)}};
            st_q.pend   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_w    = st_q.active;
    assign preempt_req = st_q.pend;

    // Active weights only move at a packet boundary.
    assert_active_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(st_q.active));

    // A write always leaves a preemption request behind it.
    assert_write_pends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> preempt_req);

endmodule

// File: rtl/txq_dwrr_core.sv
module txq_dwrr_core
    import txq_sched_pkg::*;
#(
    parameter int NQ    = 4,
    parameter int LEN_W = 16,
    parameter int W_W   = 16,
    localparam int IDX_W = $clog2(NQ),
    localparam int DEF_W = LEN_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NQ-1:0]            q_valid,
    input  logic [NQ-1:0][LEN_W-1:0] q_len,
    input  logic                     xfer_done,
    input  logic [NQ-1:0][W_W-1:0]   weight,
    input  logic                     preempt_req,
    output logic                     preempt_ack,
    output logic                     commit,
    output logic [NQ-1:0]            grant,
    output logic [IDX_W-1:0]         grant_idx
);

    typedef struct packed {
        sched_phase_e                 phase;
        logic [IDX_W-1:0]             ptr;
        logic [NQ-1:0][DEF_W-1:0]     deficit;
        logic [LEN_W-1:0]             charge;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [LEN_W-1:0] cur_len;
    logic [W_W-1:0]   cur_w;
    logic [DEF_W-1:0] cur_def;
    logic [IDX_W-1:0] nxt_ptr;
    logic [NQ-1:0]    others_valid;

    always_comb begin
        cur_len      = q_len[st_q.ptr];
        cur_w        = weight[st_q.ptr];
        cur_def      = st_q.deficit[st_q.ptr];
        nxt_ptr      = (st_q.ptr == IDX_W'(NQ - 1)) ? '0 : st_q.ptr + 1'b1;
        others_valid = q_valid & ~(NQ'(1) << st_q.ptr);

        st_d        = st_q;
        preempt_ack = 1'b0;
        commit      = (st_q.phase != PH_XFER);

        if (st_q.phase == PH_XFER) begin
            // Charge the granted length only when the transfer completes.
            if (xfer_done) begin
                st_d.deficit[st_q.ptr] = cur_def - DEF_W'(st_q.charge);
                st_d.phase             = PH_PICK;
            end
        end else if (preempt_req) begin
            st_d.deficit = '0;
            st_d.ptr     = '0;
            st_d.phase   = PH_CREDIT;
            preempt_ack  = 1'b1;
        end else if (st_q.phase == PH_CREDIT) begin
            if (q_valid[st_q.ptr]) begin
                st_d.deficit[st_q.ptr] = cur_def + DEF_W'(cur_w);
                st_d.phase             = PH_PICK;
            end else begin
                st_d.deficit[st_q.ptr] = '0;
                st_d.ptr               = nxt_ptr;
            end
        end else begin
            if (q_valid[st_q.ptr] && cur_def >= DEF_W'(cur_len)) begin
                st_d.phase  = PH_XFER;
                st_d.charge = cur_len;
            end else if (q_valid[st_q.ptr] && cur_w == '0 && others_valid == '0) begin
                // Zero-weight queue alone: serve it without charging.
                st_d.phase  = PH_XFER;
                st_d.charge = '0;
            end else begin
                if (!q_valid[st_q.ptr]) begin
                    st_d.deficit[st_q.ptr] = '0;
                end
                st_d.ptr   = nxt_ptr;
                st_d.phase = PH_CREDIT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase   <= PH_CREDIT;
            st_q.ptr     <= '0;
            st_q.deficit <= '0;
            st_q.charge  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        grant     = '0;
        grant_idx = '0;
        if (st_q.phase == PH_XFER) begin
            grant[st_q.ptr] = 1'b1;
            grant_idx       = st_q.ptr;
        end
    end

    // Leftover credit is below one maximum packet when fresh credit lands.
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_CREDIT && q_valid[st_q.ptr]) |-> !cur_def[DEF_W-1]);

    assert_no_underflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_XFER && xfer_done) |-> cur_def >= DEF_W'(st_q.charge));

    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        preempt_ack |=> (st_q.ptr == '0 && st_q.deficit == '0 && st_q.phase == PH_CREDIT));

    assert_idle_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase != PH_XFER && !preempt_req) |=> $stable(st_q.charge) || st_q.phase == PH_XFER);

endmodule

// File: rtl/txq_dwrr_sched.sv
module txq_dwrr_sched #(
    parameter int NQ         = 4,
    parameter int LEN_W      = 16,
    parameter int W_W        = 16,
    parameter int RST_WEIGHT = 512,
    localparam int IDX_W     = $clog2(NQ)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NQ-1:0]         q_valid,
    input  logic [NQ*LEN_W-1:0]   q_len,
    input  logic                  xfer_done,
    input  logic                  wgt_wr_en,
    input  logic [IDX_W-1:0]      wgt_wr_sel,
    input  logic [W_W-1:0]        wgt_wr_data,
    output logic [NQ-1:0]         grant,
    output logic [IDX_W-1:0]      grant_idx
);

    logic [NQ-1:0][LEN_W-1:0] len_vec;
    logic [NQ-1:0][W_W-1:0]   active_w;
    logic                     preempt_req;
    logic                     preempt_ack;
    logic                     commit;

    assign len_vec = q_len;

    txq_weight_bank #(
        .NQ         (NQ),
        .W_W        (W_W),
        .RST_WEIGHT (RST_WEIGHT)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wgt_wr_en),
        .wr_sel      (wgt_wr_sel),
        .wr_data     (wgt_wr_data),
        .commit      (commit),
        .preempt_ack (preempt_ack),
        .active_w    (active_w),
        .preempt_req (preempt_req)
    );

    txq_dwrr_core #(
        .NQ    (NQ),
        .LEN_W (LEN_W),
        .W_W   (W_W)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_valid     (q_valid),
        .q_len       (len_vec),
        .xfer_done   (xfer_done),
        .weight      (active_w),
        .preempt_req (preempt_req),
        .preempt_ack (preempt_ack),
        .commit      (commit),
        .grant       (grant),
        .grant_idx   (grant_idx)
    );

    assert_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    assert_idx_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> grant[grant_idx]);

    assert_grant_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|grant) |-> (($past(q_valid) & grant) != '0));

    assert_grant_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && !xfer_done) |=> $stable(grant));

    assert_grant_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((|grant) && xfer_done) |=> (grant == '0));

endmodule

// File: tb/sim_txq_dwrr_sched.sv
module sim_txq_dwrr_sched;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  q_valid = '0;
    logic [63:0] q_len = '0;
    logic        xfer_done = 1'b0;
    logic        wgt_wr_en = 1'b0;
    logic [1:0]  wgt_wr_sel = '0;
    logic [15:0] wgt_wr_data = '0;
    logic [3:0]  grant;
    logic [1:0]  grant_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    txq_dwrr_sched u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .q_valid     (q_valid),
        .q_len       (q_len),
        .xfer_done   (xfer_done),
        .wgt_wr_en   (wgt_wr_en),
        .wgt_wr_sel  (wgt_wr_sel),
        .wgt_wr_data (wgt_wr_data),
        .grant       (grant),
        .grant_idx   (grant_idx)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    task automatic set_len(input int q, input int len);
        q_len[q*16 +: 16] = 16'(len);
    endtask

    task automatic set_w(input int sel, input int data);
        @(negedge clk);
        wgt_wr_en   = 1'b1;
        wgt_wr_sel  = 2'(sel);
        wgt_wr_data = 16'(data);
        @(negedge clk);
        wgt_wr_en = 1'b0;
    endtask

    // Make queues valid and rewrite weight 0 in the same cycle: a clean
    // preempted start at queue 0 with all deficits cleared.
    task automatic restart(input logic [3:0] v, input int w0);
        @(negedge clk);
        q_valid     = v;
        wgt_wr_en   = 1'b1;
        wgt_wr_sel  = 2'd0;
        wgt_wr_data = 16'(w0);
        @(negedge clk);
        wgt_wr_en = 1'b0;
    endtask

    task automatic go_idle();
        q_valid = '0;
        repeat (12) @(negedge clk);
    endtask

    // Wait for a grant, check it, hold it, then complete it. An optional
    // weight write goes mid-hold or in the same cycle as xfer_done.
    task automatic take_grant(output int idx, input int hold, input bit wr_mid,
                              input bit wr_at_done, input int wsel, input int wdata);
        logic [3:0] g;
        bit seen = 1'b0;
        idx = -1;
        for (int t = 0; t < 500; t++) begin
            @(negedge clk);
            if (|grant) begin
                seen = 1'b1;
                break;
            end
        end
        chk(seen, "R4 grant arrives", 0, 1);
        if (!seen) return;
        g = grant;
        idx = int'(grant_idx);
        chk($countones(g) == 1, "R2 one-hot grant", $countones(g), 1);
        chk(g[grant_idx] == 1'b1, "R2 index matches grant", g, 1 << grant_idx);
        chk((g & q_valid) != '0, "R2 grant to valid queue", g, q_valid);
        for (int h = 0; h < hold; h++) begin
            if (h == 0 && wr_mid) begin
                wgt_wr_en   = 1'b1;
                wgt_wr_sel  = 2'(wsel);
                wgt_wr_data = 16'(wdata);
            end
            @(negedge clk);
            wgt_wr_en = 1'b0;
            chk(grant == g, "R3 R8 grant held", grant, g);
        end
        xfer_done = 1'b1;
        if (wr_at_done) begin
            wgt_wr_en   = 1'b1;
            wgt_wr_sel  = 2'(wsel);
            wgt_wr_data = 16'(wdata);
        end
        @(negedge clk);
        xfer_done = 1'b0;
        wgt_wr_en = 1'b0;
        chk(grant == '0, "R3 grant released on done", grant, 0);
    endtask

    task automatic expect_one(input int exp, input string tag);
        int idx;
        take_grant(idx, 0, 1'b0, 1'b0, 0, 0);
        chk(idx == exp, tag, idx, exp);
    endtask

    // One full round: c0 grants of queue 0, then c1 of queue 1, and so on.
    task automatic expect_round(input int c0, input int c1, input int c2, input int c3,
                                input string tag);
        int cnt[4];
        cnt[0] = c0; cnt[1] = c1; cnt[2] = c2; cnt[3] = c3;
        for (int q = 0; q < 4; q++) begin
            for (int k = 0; k < cnt[q]; k++) begin
                expect_one(q, tag);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        finish_run();
    end

    initial begin
        int idx;
        longint bytes[4];
        longint total;
        int wl[4];
        int ll[4];
        for (int q = 0; q < 4; q++) set_len(q, 128);

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(grant == '0, "R1 no grant after reset", grant, 0);
        chk(grant_idx == '0, "R1 index zero after reset", grant_idx, 0);

        // R1 + R9: reset weights of 512 and 128-byte packets give 4 each;
        // the restart writes the unchanged value 512.
        restart(4'b0011, 512);
        expect_round(4, 4, 0, 0, "R1 R9 reset weights 512");
        expect_round(4, 4, 0, 0, "R1 second round");
        go_idle();

        // R4: exact per-turn counts, weights 256/128/64/192, 64-byte packets
        for (int q = 0; q < 4; q++) set_len(q, 64);
        set_w(0, 256); set_w(1, 128); set_w(2, 64); set_w(3, 192);
        repeat (4) @(negedge clk);
        restart(4'b1111, 256);
        expect_round(4, 2, 1, 3, "R4 round one");
        // R10: a stray done while no grant is up must not disturb the order
        chk(grant == '0, "R10 no grant at stray done", grant, 0);
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        expect_round(4, 2, 1, 3, "R10 R4 round after stray done");
        go_idle();

        // R8 + R9: new weight for queue 0 written during a held grant
        restart(4'b1111, 256);
        expect_one(0, "R4 before mid write");
        expect_one(0, "R4 before mid write");
        take_grant(idx, 5, 1'b1, 1'b0, 0, 128);
        chk(idx == 0, "R8 grant under write", idx, 0);
        expect_round(2, 2, 1, 3, "R8 R9 restart with weight 128");
        go_idle();

        // R9: weight write in the same cycle as xfer_done
        restart(4'b1111, 256);
        expect_round(4, 0, 0, 0, "R9 lead-in");
        take_grant(idx, 0, 1'b0, 1'b1, 3, 192);
        chk(idx == 1, "R9 granted before collision", idx, 1);
        expect_round(4, 2, 1, 3, "R9 restart after collision");
        go_idle();

        // R6: leftover credit is dropped when the queue goes empty
        set_w(0, 64); set_w(1, 100); set_w(2, 0); set_w(3, 0);
        repeat (4) @(negedge clk);
        restart(4'b0011, 64);
        expect_one(0, "R6 first turn q0");
        expect_one(1, "R6 first turn q1 leaves 36");
        q_valid = 4'b0001;
        expect_one(0, "R6 q0 alone");
        expect_one(0, "R6 q0 alone");
        expect_one(0, "R6 q0 alone");
        q_valid = 4'b0011;
        expect_one(1, "R6 q1 returns");
        expect_one(0, "R6 q1 got only one packet");
        go_idle();

        // R7: zero-weight queue served only when alone
        set_w(0, 128); set_w(1, 0);
        repeat (4) @(negedge clk);
        restart(4'b0010, 128);
        expect_one(1, "R7 zero weight alone");
        expect_one(1, "R7 zero weight alone");
        q_valid = 4'b0011;
        for (int k = 0; k < 10; k++) expect_one(0, "R7 zero weight starved");
        q_valid = 4'b0010;
        expect_one(1, "R7 zero weight alone again");
        go_idle();

        // R5: long-run byte shares against weight ratio
        wl[0] = 1000; wl[1] = 500; wl[2] = 250; wl[3] = 1250;
        ll[0] = 100;  ll[1] = 70;  ll[2] = 30;  ll[3] = 200;
        for (int q = 0; q < 4; q++) begin
            set_len(q, ll[q]);
            set_w(q, wl[q]);
            bytes[q] = 0;
        end
        repeat (4) @(negedge clk);
        restart(4'b1111, 1000);
        total = 0;
        for (int k = 0; k < 1000; k++) begin
            take_grant(idx, 0, 1'b0, 1'b0, 0, 0);
            if (idx >= 0) begin
                bytes[idx] += ll[idx];
                total      += ll[idx];
            end
        end
        for (int q = 0; q < 4; q++) begin
            longint diff;
            diff = bytes[q] * 3000 - total * wl[q];
            if (diff < 0) diff = -diff;
            chk(diff <= longint'(2 * 3000 * 3000), "R5 byte share",
                bytes[q], (total * wl[q]) / 3000);
        end
        go_idle();

        finish_run();
    end

endmodule